// File: doc/BRIEF.md
# Parity-Checked Register File with Single-Step Rollback

This block is the operand store of a fault-tolerant processor datapath. Every write stores a parity bit along with the data word. Both read ports compare that bit against the data on every access, so a corrupted operand is flagged before it reaches any execution unit. At the start of each instruction the block saves the destination register's present contents in a rollback buffer. The save uses a third internal read path, so the fault-free case adds no cycles.

If a fault shows up while an instruction is in flight, the block spends one cycle putting the saved word back. The fault can be a parity mismatch on an operand or an external fault indication. During that cycle the block raises a retry request so that the controller re-issues the same instruction. A second fault during the re-issued instruction is treated as non-transient. It sets a sticky flag, and the block stops requesting automatic retries.

A test input flips the stored parity bit of any chosen register. This lets the detection and rollback paths be exercised without real upsets.

Top module: `chk_regfile`

## Requirements
- R1: A write stores the word and its even-parity bit (the stored bit is the XOR of all data bits). Both read ports return the addressed word combinationally, and register 0 behaves like any other register.
- R2: When the stored parity bit does not match the data on read port A or read port B, `err_flag` is high in that same cycle. It is low when both addressed registers are consistent.
- R3: A cycle with `instr_start` high saves the index, data and parity of register `dest_idx` as they were before that cycle's write. `commit` invalidates the saved entry. A fault that arrives while no valid entry is held produces no retry request.
- R4: A fault in a normal cycle while a valid entry is held raises `retry_req` for exactly one cycle, the cycle after the fault. A fault is `err_flag` or `fault_in`. After that cycle the saved register reads its saved value again.
- R5: A fault-free instruction never raises `retry_req`. A written value is readable in the cycle right after the write.
- R6: Any write presented during the restore cycle (`retry_req` high) is ignored.
- R7: A fault during the retried instruction sets `perm_fault`. The flag stays set until reset, and while it is set `retry_req` stays low.
- R8: Reset (synchronous, active high) clears every register to zero with matching parity. It also invalidates the rollback entry and clears `retry_req` and `perm_fault`.
- R9: A cycle with `inj_en` high inverts the stored parity bit of register `inj_idx` and leaves its data unchanged. A second injection into the same register makes it consistent again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_start | input | 1 | First cycle of an instruction; saves the destination register |
| dest_idx | input | 3 | Destination register of the starting instruction |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 3 | Write register index |
| wr_data | input | 32 | Write data |
| rd_idx_a | input | 3 | Read port A index |
| rd_data_a | output | 32 | Read port A data |
| rd_idx_b | input | 3 | Read port B index |
| rd_data_b | output | 32 | Read port B data |
| fault_in | input | 1 | External fault indication for the current instruction |
| commit | input | 1 | Current instruction has completed |
| inj_en | input | 1 | Test-only parity inversion enable |
| inj_idx | input | 3 | Register whose parity is inverted |
| retry_req | output | 1 | One-cycle restore pulse; controller re-issues the instruction |
| err_flag | output | 1 | Parity mismatch on either read port this cycle |
| perm_fault | output | 1 | Sticky flag: fault recurred during retry |

## Verification
The checker watches several properties on every cycle. The retry pulse must be one cycle wide, and it must always follow a detected fault. `perm_fault` must never drop once set, and no retry may be requested while it is set. A commit must invalidate the rollback entry. The bench scenarios are what show the data-level effects. They confirm that the restored register holds exactly the pre-instruction word, that a write presented during the restore cycle is lost, that parity injection is caught on each port for every register, and that a second fault turns into a permanent-fault indication.

// File: rtl/chk_rf_pkg.sv
package chk_rf_pkg;

    localparam int RF_NREG = 8;
    localparam int RF_DW   = 32;

    // Rollback controller phases
    typedef enum logic [1:0] {
        PH_RUN     = 2'd0,  // normal execution
        PH_RESTORE = 2'd1,  // putting the saved word back
        PH_RETRY   = 2'd2   // re-issued instruction in flight
    } rb_phase_t;

    // Even parity over a word of up to 64 bits (callers zero-extend)
    function automatic logic even_par64(input logic [63:0] w);
        return ^w;
    endfunction

endpackage

// File: rtl/rf_store.sv
module rf_store #(
    parameter int NREG = 8,
    parameter int DW   = 32,
    parameter int NRP  = 3,
    parameter int AW   = 3
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we,
    input  logic [AW-1:0]            waddr,
    input  logic [DW-1:0]            wdata,
    input  logic                     wpar,
    input  logic                     inj_en,
    input  logic [AW-1:0]            inj_addr,
    input  logic [NRP-1:0][AW-1:0]   raddr,
    output logic [NRP-1:0][DW-1:0]   rdata,
    output logic [NRP-1:0]           rpar
);
    logic [DW-1:0] mem [NREG];
    logic          par [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < NREG; k++) begin
                mem[k] <= '0;
                par[k] <= 1'b0;
            end
        end else begin
            for (int k = 0; k < NREG; k++) begin
                if (we && waddr == AW'(k)) begin
                    mem[k] <= wdata;
                    par[k] <= wpar ^ (inj_en && inj_addr == AW'(k));
                end else if (inj_en && inj_addr == AW'(k)) begin
                    par[k] <= ~par[k];
                end
            end
        end
    end

    for (genvar p = 0; p < NRP; p++) begin : g_rd
        assign rdata[p] = mem[raddr[p]];
        assign rpar[p]  = par[raddr[p]];
    end
endmodule

// File: rtl/rf_par_chk.sv
module rf_par_chk #(
    parameter int DW = 32
) (
    input  logic [DW-1:0] data,
    input  logic          par,
    output logic          err
);
    import chk_rf_pkg::*;
    assign err = even_par64(64'(data)) ^ par;
endmodule

// File: rtl/rf_rollback.sv
module rf_rollback #(
    parameter int DW = 32,
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          instr_start,
    input  logic [AW-1:0] dest,
    input  logic [DW-1:0] cur_data,
    input  logic          cur_par,
    input  logic          fault,
    input  logic          commit,
    output logic          restore,
    output logic [AW-1:0] rs_idx,
    output logic [DW-1:0] rs_data,
    output logic          rs_par,
    output logic          entry_valid,
    output logic          perm
);
    import chk_rf_pkg::*;

    typedef struct packed {
        logic          valid;
        logic [AW-1:0] idx;
        logic [DW-1:0] data;
        logic          par;
    } rb_entry_t;

    rb_phase_t ph;
    rb_entry_t rb;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph   <= PH_RUN;
            rb   <= '0;
            perm <= 1'b0;
        end else begin
            unique case (ph)
                PH_RUN:     if (fault && rb.valid && !perm) ph <= PH_RESTORE;
                PH_RESTORE: ph <= PH_RETRY;
                PH_RETRY: begin
                    if (fault) begin
                        perm <= 1'b1;
                        ph   <= PH_RUN;
                    end else if (commit) begin
                        ph <= PH_RUN;
                    end
                end
                default:    ph <= PH_RUN;
            endcase
            if (ph != PH_RESTORE) begin
                if (commit)      rb.valid <= 1'b0;
                if (instr_start) rb <= '{valid: 1'b1, idx: dest, data: cur_data, par: cur_par};
            end
        end
    end

    assign restore     = (ph == PH_RESTORE);
    assign rs_idx      = rb.idx;
    assign rs_data     = rb.data;
    assign rs_par      = rb.par;
    assign entry_valid = rb.valid;
endmodule

// File: rtl/chk_regfile.sv
module chk_regfile #(
    parameter int NREG = chk_rf_pkg::RF_NREG,
    parameter int DW   = chk_rf_pkg::RF_DW,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          instr_start,
    input  logic [AW-1:0] dest_idx,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_idx_a,
    output logic [DW-1:0] rd_data_a,
    input  logic [AW-1:0] rd_idx_b,
    output logic [DW-1:0] rd_data_b,
    input  logic          fault_in,
    input  logic          commit,
    input  logic          inj_en,
    input  logic [AW-1:0] inj_idx,
    output logic          retry_req,
    output logic          err_flag,
    output logic          perm_fault
);
    import chk_rf_pkg::*;

    localparam int NRP = 3;   // operand A, operand B, rollback capture
    localparam int NOP = 2;

    logic [NRP-1:0][AW-1:0] raddr;
    logic [NRP-1:0][DW-1:0] rdata;
    logic [NRP-1:0]         rpar;
    logic [NOP-1:0]         op_err;

    logic          restore;
    logic [AW-1:0] rs_idx;
    logic [DW-1:0] rs_data;
    logic          rs_par;
    logic          rb_valid;

    logic          st_we;
    logic [AW-1:0] st_addr;
    logic [DW-1:0] st_data;
    logic          st_par;

    assign raddr[0] = rd_idx_a;
    assign raddr[1] = rd_idx_b;
    assign raddr[2] = dest_idx;

    // Restore takes priority; normal writes are dropped in that cycle
    assign st_we   = restore | wr_en;
    assign st_addr = restore ? rs_idx  : wr_idx;
    assign st_data = restore ? rs_data : wr_data;
    assign st_par  = restore ? rs_par  : even_par64(64'(wr_data));

    rf_store #(.NREG(NREG), .DW(DW), .NRP(NRP), .AW(AW)) u_store (
        .clk      (clk),
        .rst      (rst),
        .we       (st_we),
        .waddr    (st_addr),
        .wdata    (st_data),
        .wpar     (st_par),
        .inj_en   (inj_en),
        .inj_addr (inj_idx),
        .raddr    (raddr),
        .rdata    (rdata),
        .rpar     (rpar)
    );

    for (genvar p = 0; p < NOP; p++) begin : g_chk
        rf_par_chk #(.DW(DW)) u_chk (
            .data (rdata[p]),
            .par  (rpar[p]),
            .err  (op_err[p])
        );
    end

    rf_rollback #(.DW(DW), .AW(AW)) u_rb (
        .clk         (clk),
        .rst         (rst),
        .instr_start (instr_start),
        .dest        (dest_idx),
        .cur_data    (rdata[2]),
        .cur_par     (rpar[2]),
        .fault       (err_flag | fault_in),
        .commit      (commit),
        .restore     (restore),
        .rs_idx      (rs_idx),
        .rs_data     (rs_data),
        .rs_par      (rs_par),
        .entry_valid (rb_valid),
        .perm        (perm_fault)
    );

    assign rd_data_a = rdata[0];
    assign rd_data_b = rdata[1];
    assign err_flag  = |op_err;
    assign retry_req = restore;
endmodule

// File: rtl/chk_regfile_sva.sv
module chk_regfile_sva (
    input logic clk,
    input logic rst,
    input logic retry_req,
    input logic err_flag,
    input logic fault_in,
    input logic perm_fault,
    input logic commit,
    input logic instr_start,
    input logic rb_valid
);
    // R4: restore pulse lasts a single cycle
    p_retry_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        retry_req |=> !retry_req);

    // R4: a restore is always caused by a fault in the previous cycle
    p_retry_cause_r4: assert property (@(posedge clk) disable iff (rst)
        retry_req |-> $past(err_flag || fault_in));

    // R7: permanent-fault flag never drops without reset
    p_perm_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        perm_fault |=> perm_fault);

    // R7: no automatic retry once the flag is set
    p_perm_no_retry_r7: assert property (@(posedge clk) disable iff (rst)
        perm_fault |-> !retry_req);

    // R3: commit without a new start invalidates the rollback entry
    p_commit_clears_r3: assert property (@(posedge clk) disable iff (rst)
        (commit && !instr_start && !retry_req) |=> !rb_valid);
endmodule

bind chk_regfile chk_regfile_sva u_sva (
    .clk         (clk),
    .rst         (rst),
    .retry_req   (retry_req),
    .err_flag    (err_flag),
    .fault_in    (fault_in),
    .perm_fault  (perm_fault),
    .commit      (commit),
    .instr_start (instr_start),
    .rb_valid    (rb_valid)
);

// File: tb/tb_chk_regfile.sv
module tb_chk_regfile;
    localparam int NREG = 8;
    localparam int DW   = 32;
    localparam int AW   = 3;

    logic          clk = 1'b0;
    logic          rst;
    logic          instr_start, wr_en, fault_in, commit, inj_en;
    logic [AW-1:0] dest_idx, wr_idx, rd_idx_a, rd_idx_b, inj_idx;
    logic [DW-1:0] wr_data, rd_data_a, rd_data_b;
    logic          retry_req, err_flag, perm_fault;

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    logic [DW-1:0] model [NREG];

    always #4 clk = ~clk;   // 125 MHz

    chk_regfile dut (
        .clk(clk), .rst(rst), .instr_start(instr_start), .dest_idx(dest_idx),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_idx_a(rd_idx_a), .rd_data_a(rd_data_a),
        .rd_idx_b(rd_idx_b), .rd_data_b(rd_data_b),
        .fault_in(fault_in), .commit(commit), .inj_en(inj_en), .inj_idx(inj_idx),
        .retry_req(retry_req), .err_flag(err_flag), .perm_fault(perm_fault)
    );

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        instr_start = 0; wr_en = 0; fault_in = 0; commit = 0; inj_en = 0;
        dest_idx = 0; wr_idx = 0; wr_data = 0; inj_idx = 0;
    endtask

    task automatic tick();
        @(negedge clk);
        idle();
    endtask

    task automatic rd(input int a, input int b);
        rd_idx_a = AW'(a);
        rd_idx_b = AW'(b);
        #1;
    endtask

    task automatic wr(input int i, input logic [DW-1:0] d);
        wr_en = 1; wr_idx = AW'(i); wr_data = d;
        model[i] = d;
    endtask

    initial begin
        idle();
        rd_idx_a = 0; rd_idx_b = 0;
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;

        // R8: reset state
        for (int i = 0; i < NREG; i++) begin
            model[i] = '0;
            rd(i, NREG - 1 - i);
            check("R8 reg zero A", rd_data_a, '0);
            check("R8 reg zero B", rd_data_b, '0);
            check("R8 no err", 32'(err_flag), 0);
        end
        check("R8 retry low", 32'(retry_req), 0);
        check("R8 perm low", 32'(perm_fault), 0);

        // R1/R5: write sweep, each value visible one cycle later, no retry
        for (int i = 0; i < NREG; i++) begin
            wr(i, 32'hA5C3_0F1E ^ (32'(i) * 32'h0101_0111) ^ (32'(i) << 29));
            tick();
            rd(i, i);
            check("R5 next-cycle read", rd_data_a, model[i]);
            check("R5 no retry", 32'(retry_req), 0);
        end
        // R1/R2: all port pairs return data without errors
        for (int a = 0; a < NREG; a++)
            for (int b = 0; b < NREG; b++) begin
                rd(a, b);
                check("R1 port A", rd_data_a, model[a]);
                check("R1 port B", rd_data_b, model[b]);
                check("R2 clean err", 32'(err_flag), 0);
            end

        // R9/R2: inject each register, detect on each port, clear again
        for (int i = 0; i < NREG; i++) begin
            inj_en = 1; inj_idx = AW'(i);
            tick();
            rd(i, (i + 1) % NREG);
            check("R2 err port A", 32'(err_flag), 1);
            check("R9 data kept", rd_data_a, model[i]);
            rd((i + 2) % NREG, i);
            check("R2 err port B", 32'(err_flag), 1);
            rd((i + 1) % NREG, (i + 3) % NREG);
            check("R2 other regs clean", 32'(err_flag), 0);
            inj_en = 1; inj_idx = AW'(i);
            tick();
            rd(i, i);
            check("R9 reinjection clears", 32'(err_flag), 0);
        end
        rd(0, 0);

        // R3/R4/R6: transient fault rolls back register 5
        begin
            logic [DW-1:0] old5, old2;
            old5 = model[5]; old2 = model[2];
            instr_start = 1; dest_idx = 5; wr(5, 32'hDEAD_BEEF);
            tick();
            rd(5, 0);
            check("R1 new value", rd_data_a, 32'hDEAD_BEEF);
            fault_in = 1;
            tick();
            check("R4 retry pulse", 32'(retry_req), 1);
            wr_en = 1; wr_idx = 2; wr_data = 32'h1111_2222;   // must be dropped
            tick();
            model[5] = old5;
            check("R4 single pulse", 32'(retry_req), 0);
            rd(5, 2);
            check("R4 restored value", rd_data_a, old5);
            check("R6 write blocked", rd_data_b, old2);
            check("R4 restored parity", 32'(err_flag), 0);
            // re-issue, then commit
            instr_start = 1; dest_idx = 5; wr(5, 32'hDEAD_BEEF);
            tick();
            commit = 1;
            tick();
            check("R3 commit no perm", 32'(perm_fault), 0);
            fault_in = 1;
            tick();
            check("R3 no entry no retry", 32'(retry_req), 0);
            rd(5, 5);
            check("R3 committed value", rd_data_a, 32'hDEAD_BEEF);
        end

        // R4: parity error on an operand triggers rollback of register 1
        begin
            logic [DW-1:0] old1;
            old1 = model[1];
            inj_en = 1; inj_idx = 6;
            tick();
            instr_start = 1; dest_idx = 1; wr(1, 32'h0BAD_F00D);
            tick();
            rd(6, 0);
            check("R2 operand err", 32'(err_flag), 1);
            tick();
            check("R4 parity retry", 32'(retry_req), 1);
            rd(0, 0);
            inj_en = 1; inj_idx = 6;          // repair the operand
            tick();
            model[1] = old1;
            rd(1, 6);
            check("R4 parity restore", rd_data_a, old1);
            check("R4 operand repaired", 32'(err_flag), 0);
            instr_start = 1; dest_idx = 1; wr(1, 32'h0BAD_F00D);
            tick();
            commit = 1;
            tick();
            check("R7 clean retry no perm", 32'(perm_fault), 0);
        end

        // R7: repeated fault during the retry becomes permanent
        rd(0, 0);
        instr_start = 1; dest_idx = 4; wr(4, 32'h4444_0004);
        tick();
        fault_in = 1;
        tick();
        check("R7 first retry", 32'(retry_req), 1);
        tick();
        instr_start = 1; dest_idx = 4; wr(4, 32'h4444_0004);
        tick();
        fault_in = 1;
        tick();
        check("R7 perm set", 32'(perm_fault), 1);
        check("R7 no second retry", 32'(retry_req), 0);
        fault_in = 1;
        tick();
        tick();
        check("R7 still no retry", 32'(retry_req), 0);
        check("R7 sticky", 32'(perm_fault), 1);

        // R8: reset clears everything again
        rst = 1;
        tick();
        rst = 0;
        #1;
        check("R8 perm cleared", 32'(perm_fault), 0);
        check("R8 retry cleared", 32'(retry_req), 0);
        for (int i = 0; i < NREG; i++) begin
            rd(i, i);
            check("R8 reg cleared", rd_data_a, '0);
            check("R8 parity clean", 32'(err_flag), 0);
        end
        fault_in = 1;
        tick();
        check("R8 entry invalid", 32'(retry_req), 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule